// File: doc/BRIEF.md
# Two-Layer Depth-Gated Coxel Blender

This block updates one composite-buffer element (a coxel) per clock. Each coxel takes two contributions in that step, in back-to-front order. The first is a translucent polygon fragment blended over the stored colour. The second is a volume sample blended over that intermediate result. Each blend has the linear-interpolation form `base + (top - base) * alpha`. One subtraction result feeds each multiply and is reused by the add that follows it. Because of this, two layers cost two multiplies instead of four, and the volume path keeps its rate of one sample per clock.

The stored opaque depth travels with the coxel and gates the update. The volume slice index acts as the depth of the current step. The colour changes only when that index is strictly nearer than the stored depth. Otherwise the stored colour comes out untouched.

Arithmetic is 8-bit normalised fixed point: a code of 255 means 1.0. Each product is rounded to the nearest value. The pipeline is six registers deep. It takes a new coxel on every clock with no bubbles, and a valid flag travels with the data.

Top module: `lyr_compositor`

## Requirements
- R1: A coxel presented with `in_valid` high on one rising edge appears with `out_valid` high exactly six rising edges later. `out_valid` is low in every other cycle. A new coxel can enter on every clock.
- R2: Colour words pack four 8-bit channels. Bits [31:24] hold red, [23:16] green, [15:8] blue and [7:0] alpha. Bits [7:0] of the fragment word give the fragment opacity. All four channels of the coxel are blended, including alpha, using t = C + (P - C)·ap.
- R3: The second layer is then applied per channel as out = t + (V - t)·av. Here av is bits [7:0] of the sample word.
- R4: Each product term is computed as sign(d)·floor((|d|·a + 127) / 255), where d is the signed difference and a is the 8-bit opacity. No result leaves the range 0..255.
- R5: Blending happens only when the slice index is strictly less than the stored depth. When the index is equal or greater, the output colour equals the input coxel colour.
- R6: The output depth always equals the depth that entered with the coxel.
- R7: With fragment opacity 0, the result equals the volume sample alone blended over the stored colour.
- R8: With both opacities at 255 and the gate open, the output equals the sample word. With both opacities at 0, the output equals the stored colour.
- R9: While `rst_n` is low, `out_valid` is low, even if `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input coxel is valid this cycle |
| coxel_rgba_i | input | 32 | Stored coxel colour (R,G,B,A from msb) |
| coxel_depth_i | input | DEPTH_W (24) | Stored opaque depth |
| frag_rgba_i | input | 32 | Translucent polygon fragment colour and opacity |
| samp_rgba_i | input | 32 | Volume sample colour and opacity |
| slice_idx_i | input | DEPTH_W (24) | Volume slice index used as depth |
| out_valid | output | 1 | Output coxel is valid |
| coxel_rgba_o | output | 32 | Updated coxel colour |
| coxel_depth_o | output | DEPTH_W (24) | Depth carried through unchanged |

## Verification
A fragment-only pattern (sample opacity 0) and a sample-only pattern (fragment opacity 0) test each layer's interpolation alone. A mixed pattern then shows whether the second layer really consumes the first layer's result rather than the stored colour.

Unit differences at opacities 127 and 128, in both signs, check the rounding and sign restoration. Opacities of 0 and 255 check the exact pass-through and replacement limits.

Slice indices equal to, one below and above the stored depth, including zero and full scale, check that the depth gate is strict. A long stream of back-to-back and gapped random coxels then checks that valid flags, depths and colours stay aligned through all six stages.

// File: rtl/lyr_pkg.sv
// Shared widths, vector types and the rounding divide used by the blender.
// Assumes opacity codes 0..2^CH_W-1 map linearly onto 0..1.
package lyr_pkg;
    parameter int CH_W = 8;
    parameter int N_CH = 4;
    localparam int PIX_W  = CH_W * N_CH;
    localparam int PROD_W = 2 * CH_W;
    localparam int HALF   = ((1 << CH_W) - 1) / 2;

    typedef logic [N_CH-1:0][CH_W-1:0]   pix_t;
    typedef logic [N_CH-1:0][CH_W:0]     diff_t;
    typedef logic [N_CH-1:0][PROD_W-1:0] prod_t;

    // Rounded division of a product by (2^CH_W - 1) using shift-add only.
    function automatic logic [CH_W-1:0] round_scale(input logic [PROD_W-1:0] p);
        logic [PROD_W:0] x;
        logic [PROD_W:0] q;
        x = {1'b0, p} + (PROD_W+1)'(HALF);
        q = (x + (PROD_W+1)'(1) + (x >> CH_W)) >> CH_W;
        return q[CH_W-1:0];
    endfunction
endpackage

// File: rtl/lyr_delay.sv
// Fixed-length register chain for sideband data.
// Assumes N >= 1; every stage clears on reset.
module lyr_delay #(
    parameter int W = 8,
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] pipe [N];

    // Shift the chain by one stage each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d_i;
            for (int i = 1; i < N; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q_o = pipe[N-1];
endmodule

// File: rtl/lyr_sub_stage.sv
// Registered per-channel signed difference (top - base).
// Assumes unsigned channel inputs; result carries one extra sign bit.
module lyr_sub_stage
    import lyr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  pix_t  minu_i,
    input  pix_t  subt_i,
    output diff_t diff_o
);
    diff_t diff_w;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        assign diff_w[g] = {1'b0, minu_i[g]} - {1'b0, subt_i[g]};
    end

    // Register the differences of all channels.
    always_ff @(posedge clk) begin
        if (!rst_n) diff_o <= '0;
        else        diff_o <= diff_w;
    end
endmodule

// File: rtl/lyr_mul_stage.sv
// Registered magnitude-times-opacity product with the sign kept aside.
// Assumes differences lie in -(2^CH_W-1)..(2^CH_W-1).
module lyr_mul_stage
    import lyr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  diff_t           diff_i,
    input  logic [CH_W-1:0] alpha_i,
    output prod_t           prod_o,
    output logic [N_CH-1:0] neg_o
);
    prod_t           prod_w;
    logic [N_CH-1:0] neg_w;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic [CH_W:0] mag_w;
        assign neg_w[g]  = diff_i[g][CH_W];
        assign mag_w     = neg_w[g] ? (~diff_i[g] + 1'b1) : diff_i[g];
        assign prod_w[g] = PROD_W'(mag_w[CH_W-1:0]) * PROD_W'(alpha_i);
    end

    // Register products and signs together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_o <= '0;
            neg_o  <= '0;
        end else begin
            prod_o <= prod_w;
            neg_o  <= neg_w;
        end
    end
endmodule

// File: rtl/lyr_acc_stage.sv
// Registered base plus or minus the rounded scaled product.
// Assumes the rounded term never exceeds the distance to the blend target,
// so the sum stays inside the channel range.
module lyr_acc_stage
    import lyr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  pix_t            base_i,
    input  prod_t           prod_i,
    input  logic [N_CH-1:0] neg_i,
    output pix_t            sum_o
);
    pix_t sum_w;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic [CH_W-1:0] r_w;
        assign r_w      = round_scale(prod_i[g]);
        assign sum_w[g] = neg_i[g] ? (base_i[g] - r_w) : (base_i[g] + r_w);
    end

    // Register the interpolated channels.
    always_ff @(posedge clk) begin
        if (!rst_n) sum_o <= '0;
        else        sum_o <= sum_w;
    end
endmodule

// File: rtl/lyr_compositor.sv
// Two-layer blender: fragment over coxel, then sample over that, six stages.
// The depth gate is applied by zeroing both opacities at entry, which makes
// both interpolations return their base exactly.
// Assumes slice index and stored depth use the same scale.
module lyr_compositor
    import lyr_pkg::*;
#(
    parameter int DEPTH_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [PIX_W-1:0]   coxel_rgba_i,
    input  logic [DEPTH_W-1:0] coxel_depth_i,
    input  logic [PIX_W-1:0]   frag_rgba_i,
    input  logic [PIX_W-1:0]   samp_rgba_i,
    input  logic [DEPTH_W-1:0] slice_idx_i,
    output logic               out_valid,
    output logic [PIX_W-1:0]   coxel_rgba_o,
    output logic [DEPTH_W-1:0] coxel_depth_o
);
    localparam int LAT = 6;

    pix_t            cox_w, frag_w, samp_w;
    logic            gate_open;
    logic [CH_W-1:0] ap_in, av_in, ap1, av4;
    diff_t           d1, d4;
    prod_t           m2, m5;
    logic [N_CH-1:0] n2, n5;
    pix_t            c2, v3, t3, t5, o6;

    assign cox_w  = coxel_rgba_i;
    assign frag_w = frag_rgba_i;
    assign samp_w = samp_rgba_i;

    assign gate_open = slice_idx_i < coxel_depth_i;
    assign ap_in     = gate_open ? frag_w[0] : '0;
    assign av_in     = gate_open ? samp_w[0] : '0;

    // Stage 1: fragment minus stored colour
    lyr_sub_stage u_d1 (.clk(clk), .rst_n(rst_n), .minu_i(frag_w), .subt_i(cox_w), .diff_o(d1));
    lyr_delay #(.W(CH_W), .N(1)) u_ap (.clk(clk), .rst_n(rst_n), .d_i(ap_in), .q_o(ap1));
    lyr_delay #(.W(PIX_W), .N(2)) u_cc (.clk(clk), .rst_n(rst_n), .d_i(cox_w), .q_o(c2));

    // Stage 2: scale by fragment opacity
    lyr_mul_stage u_m2 (.clk(clk), .rst_n(rst_n), .diff_i(d1), .alpha_i(ap1), .prod_o(m2), .neg_o(n2));

    // Stage 3: first-layer result
    lyr_acc_stage u_t3 (.clk(clk), .rst_n(rst_n), .base_i(c2), .prod_i(m2), .neg_i(n2), .sum_o(t3));
    lyr_delay #(.W(PIX_W), .N(3)) u_cv (.clk(clk), .rst_n(rst_n), .d_i(samp_w), .q_o(v3));

    // Stage 4: sample minus first-layer result
    lyr_sub_stage u_d4 (.clk(clk), .rst_n(rst_n), .minu_i(v3), .subt_i(t3), .diff_o(d4));
    lyr_delay #(.W(CH_W), .N(4)) u_av (.clk(clk), .rst_n(rst_n), .d_i(av_in), .q_o(av4));
    lyr_delay #(.W(PIX_W), .N(2)) u_tt (.clk(clk), .rst_n(rst_n), .d_i(t3), .q_o(t5));

    // Stage 5: scale by sample opacity
    lyr_mul_stage u_m5 (.clk(clk), .rst_n(rst_n), .diff_i(d4), .alpha_i(av4), .prod_o(m5), .neg_o(n5));

    // Stage 6: final coxel colour
    lyr_acc_stage u_o6 (.clk(clk), .rst_n(rst_n), .base_i(t5), .prod_i(m5), .neg_i(n5), .sum_o(o6));

    // Sideband alignment over the full latency
    lyr_delay #(.W(DEPTH_W), .N(LAT)) u_dep (.clk(clk), .rst_n(rst_n), .d_i(coxel_depth_i), .q_o(coxel_depth_o));
    lyr_delay #(.W(1), .N(LAT)) u_vld (.clk(clk), .rst_n(rst_n), .d_i(in_valid), .q_o(out_valid));

    assign coxel_rgba_o = o6;
endmodule

// File: rtl/lyr_compositor_chk.sv
// Property checker for the two-layer blender; attached by bind below.
// Waits until six post-reset cycles have passed before looking back six cycles.
module lyr_compositor_chk #(
    parameter int DEPTH_W = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [31:0]        coxel_rgba_i,
    input logic [DEPTH_W-1:0] coxel_depth_i,
    input logic [31:0]        frag_rgba_i,
    input logic [31:0]        samp_rgba_i,
    input logic [DEPTH_W-1:0] slice_idx_i,
    input logic               out_valid,
    input logic [31:0]        coxel_rgba_o,
    input logic [DEPTH_W-1:0] coxel_depth_o
);
    logic [2:0] age;
    logic       warm;

    // Count cycles since reset, saturating at the pipeline depth.
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= '0;
        else if (age != 3'd6) age <= age + 3'd1;
    end
    assign warm = (age == 3'd6);

    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, 6)));

    assert_depth_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid) |-> (coxel_depth_o == $past(coxel_depth_i, 6)));

    assert_gate_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && !($past(slice_idx_i, 6) < $past(coxel_depth_i, 6)))
        |-> (coxel_rgba_o == $past(coxel_rgba_i, 6)));

    assert_clear_layers_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(frag_rgba_i[7:0], 6) == 8'd0 && $past(samp_rgba_i[7:0], 6) == 8'd0)
        |-> (coxel_rgba_o == $past(coxel_rgba_i, 6)));

    assert_opaque_layers_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(slice_idx_i, 6) < $past(coxel_depth_i, 6)
         && $past(frag_rgba_i[7:0], 6) == 8'hFF && $past(samp_rgba_i[7:0], 6) == 8'hFF)
        |-> (coxel_rgba_o == $past(samp_rgba_i, 6)));
endmodule

bind lyr_compositor lyr_compositor_chk #(.DEPTH_W(DEPTH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .coxel_rgba_i(coxel_rgba_i), .coxel_depth_i(coxel_depth_i),
    .frag_rgba_i(frag_rgba_i), .samp_rgba_i(samp_rgba_i), .slice_idx_i(slice_idx_i),
    .out_valid(out_valid), .coxel_rgba_o(coxel_rgba_o), .coxel_depth_o(coxel_depth_o)
);

// File: tb/lyr_compositor_test.sv
module lyr_compositor_test;
    localparam int DW  = 24;
    localparam int LAT = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [31:0]   coxel_rgba_i, frag_rgba_i, samp_rgba_i;
    logic [DW-1:0] coxel_depth_i, slice_idx_i;
    logic          out_valid;
    logic [31:0]   coxel_rgba_o;
    logic [DW-1:0] coxel_depth_o;

    int checks = 0;
    int errors = 0;

    bit          exp_v_q[$];
    logic [31:0] exp_c_q[$];
    logic [DW-1:0] exp_d_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;  // 20 time units per period: 50 MHz

    lyr_compositor #(.DEPTH_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .coxel_rgba_i(coxel_rgba_i), .coxel_depth_i(coxel_depth_i),
        .frag_rgba_i(frag_rgba_i), .samp_rgba_i(samp_rgba_i), .slice_idx_i(slice_idx_i),
        .out_valid(out_valid), .coxel_rgba_o(coxel_rgba_o), .coxel_depth_o(coxel_depth_o)
    );

    // R4 rounding rule, written behaviourally
    function automatic int rmul(int d, int a);
        int m;
        m = (d < 0) ? -d : d;
        m = (m * a + 127) / 255;
        return (d < 0) ? -m : m;
    endfunction

    // R2, R3, R5 reference blend
    function automatic logic [31:0] model(logic [31:0] c, logic [DW-1:0] dep,
                                          logic [31:0] p, logic [31:0] s, logic [DW-1:0] sl);
        int ap, av, cc, t, o;
        logic [31:0] r;
        ap = (sl < dep) ? int'(p[7:0]) : 0;
        av = (sl < dep) ? int'(s[7:0]) : 0;
        for (int ch = 0; ch < 4; ch++) begin
            cc = int'(c[ch*8 +: 8]);
            t  = cc + rmul(int'(p[ch*8 +: 8]) - cc, ap);
            o  = t + rmul(int'(s[ch*8 +: 8]) - t, av);
            r[ch*8 +: 8] = o[7:0];
        end
        return r;
    endfunction

    task automatic step(bit v, logic [31:0] c, logic [DW-1:0] dep, logic [31:0] p,
                        logic [31:0] s, logic [DW-1:0] sl, string tag);
        bit ev; logic [31:0] ec; logic [DW-1:0] ed; string et;
        @(negedge clk);
        if (exp_v_q.size() == LAT) begin
            ev = exp_v_q.pop_front(); ec = exp_c_q.pop_front();
            ed = exp_d_q.pop_front(); et = tag_q.pop_front();
            checks++;
            if (out_valid !== ev) begin
                errors++;
                $display("FAIL %s R1 valid got %0b exp %0b", et, out_valid, ev);
            end else if (ev && (coxel_rgba_o !== ec || coxel_depth_o !== ed)) begin
                errors++;
                $display("FAIL %s colour got %08h exp %08h depth got %06h exp %06h",
                         et, coxel_rgba_o, ec, coxel_depth_o, ed);
            end
        end
        in_valid = v; coxel_rgba_i = c; coxel_depth_i = dep;
        frag_rgba_i = p; samp_rgba_i = s; slice_idx_i = sl;
        exp_v_q.push_back(v);
        exp_c_q.push_back(model(c, dep, p, s, sl));
        exp_d_q.push_back(dep);
        tag_q.push_back(tag);
    endtask

    task automatic flush();
        for (int i = 0; i < LAT; i++) step(1'b0, '0, '0, '0, '0, '0, "R1 idle");
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        #(20 * 50000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b1;
        coxel_rgba_i = 32'h11223344; coxel_depth_i = 24'hFFFFFF;
        frag_rgba_i = 32'h55667788; samp_rgba_i = 32'h99AABBCC; slice_idx_i = '0;
        repeat (8) @(negedge clk);
        checks++;  // R9 valid held low under reset
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R9 reset valid got %0b exp 0", out_valid);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;

        // R2 fragment layer only
        step(1, 32'h10305070, 24'h000100, 32'hF0B07080, 32'h00000000, 24'h000010, "R2 fragment layer");
        // R7 zero fragment opacity, sample only
        step(1, 32'h10305070, 24'h000100, 32'hFFFFFF00, 32'h8040C040, 24'h000010, "R7 sample only");
        // R3 both layers chained
        step(1, 32'hA0305070, 24'h000100, 32'h20E08099, 32'hF0101033, 24'h000010, "R3 two layers");
        // R8 opaque layers give the sample
        step(1, 32'h0F0F0F0F, 24'h000100, 32'hFFFFFFFF, 32'h123456FF, 24'h000000, "R8 opaque");
        // R8 clear layers keep the coxel
        step(1, 32'hC3A59600, 24'h000100, 32'h00000000, 32'hFFFFFF00, 24'h000000, "R8 clear");
        // R4 rounding: +1 at 128, 0 at 127, -1 at 128
        step(1, 32'h64646480, 24'h000100, 32'h65656580, 32'h00000000, 24'h000000, "R4 round up");
        step(1, 32'h6464647F, 24'h000100, 32'h6565657F, 32'h00000000, 24'h000000, "R4 round down");
        step(1, 32'h65656580, 24'h000100, 32'h64646480, 32'h00000000, 24'h000000, "R4 negative");
        // R5 gate boundaries
        step(1, 32'h13579BDF, 24'h000200, 32'hFFFFFFFF, 32'h000000FF, 24'h000200, "R5 equal depth");
        step(1, 32'h13579BDF, 24'h000200, 32'hFFFFFFFF, 32'h000000FF, 24'h0001FF, "R5 one nearer");
        step(1, 32'h13579BDF, 24'h000000, 32'h808080FF, 32'h404040FF, 24'h000000, "R5 zero depth");
        step(1, 32'h2468ACE0, 24'hFFFFFF, 32'h808080C0, 32'h40404040, 24'hFFFFFE, "R5 full scale");
        step(1, 32'h2468ACE0, 24'h000100, 32'h808080C0, 32'h40404040, 24'h000300, "R5 farther");
        flush();

        // R1 R6 stream: back-to-back with occasional gaps
        for (int i = 0; i < 400; i++) begin
            logic [DW-1:0] dep;
            dep = DW'($urandom);
            step(($urandom % 5) != 0, $urandom, dep, $urandom, $urandom,
                 (i % 3 == 0) ? dep - DW'(1) : DW'($urandom), "R1 R6 stream");
        end
        flush();
        flush();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule